// File: doc/BRIEF.md
# Serial SAR Conversion Sequencer

This block is the digital control core of an 8-bit successive-approximation converter with a three-wire serial link. It runs on the serial clock and is framed by an active-low chip select. While chip select is low, the block works through a fixed sequence: an optional address phase on the serial input, one sampling clock, eight approximation steps, and a second readout of the result.

The address phase picks the input channel and the single-ended or differential mode. Each approximation step presents a trial code to an external DAC and reads back an external comparator. Each bit is placed on the serial output as soon as it is decided, most significant bit first. The same word is then sent again, least significant bit first.

The serial output and the status line each have an output enable, and both are released as soon as chip select goes high. A low-power flag tells the analog section when no conversion is running. A parameter selects one of two variants: a two-channel variant with an address phase, or a fixed-channel variant without one.

Top module: `sar_seq_top`

## Requirements
- R1: In the addressed variant, rising edges with chip select low and the serial input low are ignored until the first edge that sees the serial input high (the start bit). Until sampling, the output enable stays low and the low-power flag stays high. The fixed-channel variant skips the address phase and treats its first edge as a settling clock.
- R2: In the addressed variant, the edge after the start bit captures the mode bit (1 = single-ended, 0 = differential, shown on `diff_o` as its inverse). The next edge captures the channel bit. In single-ended mode this bit picks channel 0 or 1. In differential mode it picks which input is positive: 0 = input 0 positive, 1 = input 1 positive. Both selects stay unchanged while the conversion runs.
- R3: The edge after the address phase is the sampling edge. This is edge 4 counted from the start bit, or edge 2 from the chip-select fall in the fixed variant. On it the trial code becomes 1000_0000, the status goes high and the output enable goes high.
- R4: Each of the next 8 edges decides one bit, starting with the MSB. The bit under trial is kept if the comparator input is high (input at or above the trial code) and cleared otherwise, and the next lower bit is set as the new trial. After the 8th step the code output holds the result.
- R5: Each decided bit appears on the serial output after the falling edge that follows its decision edge.
- R6: After the LSB has been sent, the next 7 rising edges put result bits 1 to 7 on the serial output in that order, each after the following falling edge.
- R7: The status stays high from the sampling edge through the edge that shifts out bit 7. On the next edge the status goes low and the output enable drops.
- R8: A rising edge that sees chip select high clears the code register to zero and sends the block back to waiting for a frame. The output enable falls at once when chip select rises, without waiting for a clock.
- R9: The low-power flag is high whenever chip select is high or no conversion is running. It is low from the sampling edge until the status falls.
- R10: In differential mode, a negative input above the positive input gives a result of 0000_0000.
- R11: When the start bit arrives on the first edge, the last MSB-first bit is decided on edge 12 in the addressed variant and edge 10 in the fixed variant. A frame cut off there, with one chip-select-high clock after it, lasts 13 or 11 clocks, and the next frame starts cleanly.
- R12: A synchronous active-high reset clears the code, status and selects, and puts the block in the waiting state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select framing a conversion |
| di | input | 1 | Serial address input, sampled on rising edges |
| cmp_i | input | 1 | Comparator decision, high when the input is at or above the trial code |
| dac_code_o | output | RES | Trial code to the DAC; holds the result after the last step |
| ch_sel_o | output | 1 | Channel select or differential polarity |
| diff_o | output | 1 | High for differential mode |
| do_o | output | 1 | Serial result data, updated on falling edges |
| busy_o | output | 1 | Conversion status |
| drv_en_o | output | 1 | Output enable for do_o and busy_o |
| lp_o | output | 1 | Low-power flag |

## Verification
The bench sends frames with a random number of idle low bits before the start bit. A decoder that takes the first edge after the chip-select fall as the start would put every bit of the result in the wrong clock. The bench also aborts frames in the middle of the approximation and right after the MSB-first pass, then sends a fresh frame. A design that left the code register loaded, or released the output only on a clock edge, would then show stale trial codes or a driven output while chip select is high. Differential frames with the negative input above, or equal to, the positive input must give a zero result, and the LSB-first readout must match the MSB-first word bit for bit, with the LSB shared between the two passes.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [2:0] {
    SQ_WAIT,
    SQ_MODE,
    SQ_CHAN,
    SQ_SAMPLE,
    SQ_CONV,
    SQ_SHIFT,
    SQ_DONE
  } seq_state_e;
endpackage

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int RES = 8,
  parameter bit ADDRESSED = 1'b1,
  localparam int IW = $clog2(RES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          di,
  output seq_state_e    st_o,
  output logic [IW-1:0] idx_o,
  output logic          diff_o,
  output logic          ch_o,
  output logic          busy_o,
  output logic          drive_o
);
  localparam logic [IW-1:0] TOP_IDX = IW'(RES - 1);

  seq_state_e st_q;

  always_ff @(posedge clk) begin
    if (rst || cs_n) begin
      st_q    <= SQ_WAIT;
      idx_o   <= '0;
      busy_o  <= 1'b0;
      drive_o <= 1'b0;
      if (rst) begin
        diff_o <= 1'b0;
        ch_o   <= 1'b0;
      end
    end else begin
      case (st_q)
        SQ_WAIT: begin
          if (!ADDRESSED) st_q <= SQ_SAMPLE;
          else if (di)    st_q <= SQ_MODE;
        end
        SQ_MODE: begin
          diff_o <= ~di;
          st_q   <= SQ_CHAN;
        end
        SQ_CHAN: begin
          ch_o <= di;
          st_q <= SQ_SAMPLE;
        end
        SQ_SAMPLE: begin
          busy_o  <= 1'b1;
          drive_o <= 1'b1;
          idx_o   <= TOP_IDX;
          st_q    <= SQ_CONV;
        end
        SQ_CONV: begin
          if (idx_o == '0) begin
            idx_o <= IW'(1);
            st_q  <= SQ_SHIFT;
          end else begin
            idx_o <= idx_o - 1'b1;
          end
        end
        SQ_SHIFT: begin
          if (idx_o == TOP_IDX) st_q <= SQ_DONE;
          else                  idx_o <= idx_o + 1'b1;
        end
        default: begin
          busy_o  <= 1'b0;
          drive_o <= 1'b0;
        end
      endcase
    end
  end

  assign st_o = st_q;
endmodule

// File: rtl/sar_seq_sar.sv
module sar_seq_sar #(
  parameter int RES = 8,
  localparam int IW = $clog2(RES)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           load,
  input  logic           step,
  input  logic [IW-1:0]  idx,
  input  logic           cmp,
  output logic [RES-1:0] code_o
);
  for (genvar i = 0; i < RES; i++) begin : g_bit
    logic b_q;
    logic set_next;
    if (i < RES - 1) begin : g_low
      assign set_next = (idx == IW'(i + 1));
    end else begin : g_top
      assign set_next = 1'b0;
    end
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        b_q <= 1'b0;
      end else if (load) begin
        b_q <= (i == RES - 1);
      end else if (step) begin
        if (idx == IW'(i)) b_q <= cmp;
        else if (set_next) b_q <= 1'b1;
      end
    end
    assign code_o[i] = b_q;
  end
endmodule

// File: rtl/sar_seq_dout.sv
module sar_seq_dout
  import sar_seq_pkg::*;
#(
  parameter int RES = 8,
  localparam int IW = $clog2(RES)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cs_n,
  input  seq_state_e     st,
  input  logic [IW-1:0]  idx,
  input  logic           cmp,
  input  logic [RES-1:0] code,
  input  logic           drive,
  input  logic           busy,
  output logic           do_o,
  output logic           en_o,
  output logic           lp_o
);
  logic bit_q;

  always_ff @(posedge clk) begin
    if (rst || cs_n) begin
      bit_q <= 1'b0;
    end else begin
      case (st)
        SQ_CONV:  bit_q <= cmp;
        SQ_SHIFT: bit_q <= code[idx];
        default:  bit_q <= 1'b0;
      endcase
    end
  end

  // Launch on the falling edge so the far side samples on the rising edge.
  always_ff @(negedge clk) begin
    if (rst) do_o <= 1'b0;
    else     do_o <= bit_q;
  end

  // Release without waiting for a clock once chip select rises.
  assign en_o = ~cs_n & drive;
  assign lp_o = cs_n | ~busy;
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
  import sar_seq_pkg::*;
#(
  parameter int RES = 8,
  parameter bit ADDRESSED = 1'b1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cs_n,
  input  logic           di,
  input  logic           cmp_i,
  output logic [RES-1:0] dac_code_o,
  output logic           ch_sel_o,
  output logic           diff_o,
  output logic           do_o,
  output logic           busy_o,
  output logic           drv_en_o,
  output logic           lp_o
);
  localparam int IW = $clog2(RES);

  seq_state_e    st;
  logic [IW-1:0] idx;
  logic          drive;

  sar_seq_ctrl #(.RES(RES), .ADDRESSED(ADDRESSED)) u_ctrl (
    .clk(clk), .rst(rst), .cs_n(cs_n), .di(di),
    .st_o(st), .idx_o(idx), .diff_o(diff_o), .ch_o(ch_sel_o),
    .busy_o(busy_o), .drive_o(drive)
  );

  sar_seq_sar #(.RES(RES)) u_sar (
    .clk(clk), .rst(rst), .clr(cs_n),
    .load(st == SQ_SAMPLE), .step(st == SQ_CONV),
    .idx(idx), .cmp(cmp_i), .code_o(dac_code_o)
  );

  sar_seq_dout #(.RES(RES)) u_dout (
    .clk(clk), .rst(rst), .cs_n(cs_n), .st(st), .idx(idx),
    .cmp(cmp_i), .code(dac_code_o), .drive(drive), .busy(busy_o),
    .do_o(do_o), .en_o(drv_en_o), .lp_o(lp_o)
  );
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int RES = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           cs_n,
  input logic [RES-1:0] dac_code_o,
  input logic           ch_sel_o,
  input logic           diff_o,
  input logic           busy_o,
  input logic           drv_en_o,
  input logic           lp_o
);
  localparam logic [RES-1:0] FIRST_TRIAL = {1'b1, {(RES-1){1'b0}}};

  // R8
  abort_clear_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> (dac_code_o == '0));

  // R3
  sample_trial_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> (dac_code_o == FIRST_TRIAL));

  // R2
  mux_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !lp_o |-> ($stable(ch_sel_o) && $stable(diff_o)));

  // R9
  idle_busy_chk: assert property (@(posedge clk) disable iff (rst)
    $past(cs_n) |-> !busy_o);

  // R7
  running_drive_chk: assert property (@(posedge clk) disable iff (rst)
    !lp_o |-> drv_en_o);
endmodule

bind sar_seq_top sar_seq_chk #(.RES(RES)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .dac_code_o(dac_code_o),
  .ch_sel_o(ch_sel_o), .diff_o(diff_o), .busy_o(busy_o),
  .drv_en_o(drv_en_o), .lp_o(lp_o)
);

// File: tb/tb_sar_seq_top.sv
module tb_sar_seq_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1;
  logic di = 1'b0;
  logic [7:0] va0 = '0, va1 = '0, vf = '0;

  logic cmp_a, cmp_f;
  logic [7:0] dac_a, dac_f;
  logic ch_a, df_a, do_a, bz_a, en_a, lp_a;
  logic ch_f, df_f, do_f, bz_f, en_f, lp_f;
  logic [7:0] eff_a;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic r_do [2][32];
  logic r_en [2][32];
  logic r_bz [2][32];
  logic r_lp [2][32];
  logic [7:0] r_dac [2][32];
  logic r_ch [32];
  logic r_df [32];

  always #4 clk = ~clk;

  sar_seq_top #(.RES(8), .ADDRESSED(1'b1)) dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .di(di), .cmp_i(cmp_a),
    .dac_code_o(dac_a), .ch_sel_o(ch_a), .diff_o(df_a), .do_o(do_a),
    .busy_o(bz_a), .drv_en_o(en_a), .lp_o(lp_a)
  );

  sar_seq_top #(.RES(8), .ADDRESSED(1'b0)) dut_fix (
    .clk(clk), .rst(rst), .cs_n(cs_n), .di(di), .cmp_i(cmp_f),
    .dac_code_o(dac_f), .ch_sel_o(ch_f), .diff_o(df_f), .do_o(do_f),
    .busy_o(bz_f), .drv_en_o(en_f), .lp_o(lp_f)
  );

  function automatic logic [7:0] conv_val(input bit sgl, input bit chn,
                                          input logic [7:0] v0, input logic [7:0] v1);
    logic [7:0] p, n;
    p = chn ? v1 : v0;
    n = chn ? v0 : v1;
    if (sgl) return p;
    return (p > n) ? p - n : 8'd0;
  endfunction

  // Analog side: comparator against the DAC trial code.
  always_comb eff_a = conv_val(!df_a, ch_a, va0, va1);
  assign cmp_a = (eff_a >= dac_a);
  assign cmp_f = (vf >= dac_f);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic c, input logic d);
    cs_n = c;
    di = d;
    @(posedge clk);
    #5;
  endtask

  task automatic rec(input int k);
    r_do[0][k] = do_a; r_en[0][k] = en_a; r_bz[0][k] = bz_a;
    r_lp[0][k] = lp_a; r_dac[0][k] = dac_a;
    r_do[1][k] = do_f; r_en[1][k] = en_f; r_bz[1][k] = bz_f;
    r_lp[1][k] = lp_f; r_dac[1][k] = dac_f;
    r_ch[k] = ch_a; r_df[k] = df_a;
  endtask

  task automatic analyze(input int d, input int lead, input logic [7:0] e, input int stop);
    bit ok;
    logic [7:0] w;
    ok = 1'b1;
    for (int k = 1; k < lead && k <= stop; k++)
      if (r_en[d][k] || !r_lp[d][k]) ok = 1'b0;
    chk(ok, "R1 idle before sampling", int'(ok), 1);
    if (stop >= lead) begin
      chk(r_bz[d][lead] && r_en[d][lead] && !r_lp[d][lead] && r_dac[d][lead] == 8'h80,
          "R3 sampling edge", int'(r_dac[d][lead]), 8'h80);
    end
    if (stop >= lead + 8) begin
      for (int j = 0; j < 8; j++) w[7-j] = r_do[d][lead+1+j];
      chk(w == e, "R5 MSB-first stream", int'(w), int'(e));
      chk(r_dac[d][lead+8] == e, "R4 result code", int'(r_dac[d][lead+8]), int'(e));
    end
    if (stop >= lead + 15) begin
      w[0] = r_do[d][lead+8];
      for (int j = 1; j < 8; j++) w[j] = r_do[d][lead+8+j];
      chk(w == e, "R6 LSB-first stream", int'(w), int'(e));
      ok = 1'b1;
      for (int k = lead; k <= lead + 15; k++)
        if (!r_bz[d][k] || !r_en[d][k] || r_lp[d][k]) ok = 1'b0;
      chk(ok, "R7 R9 status during conversion", int'(ok), 1);
    end
    if (stop >= lead + 16) begin
      chk(!r_bz[d][lead+16] && !r_en[d][lead+16] && r_lp[d][lead+16],
          "R7 end of frame", int'({r_bz[d][lead+16], r_en[d][lead+16]}), 0);
    end
  endtask

  task automatic frame(input int pre, input bit sgl, input bit chn, input int stop);
    logic [7:0] ea, ef;
    logic d;
    ea = conv_val(sgl, chn, va0, va1);
    ef = vf;
    for (int k = 1; k <= stop; k++) begin
      if (k <= pre)          d = 1'b0;
      else if (k == pre + 1) d = 1'b1;
      else if (k == pre + 2) d = sgl;
      else if (k == pre + 3) d = chn;
      else                   d = 1'($urandom % 2);
      step(1'b0, d);
      rec(k);
    end
    cs_n = 1'b1;
    #1;
    // R8: release at once, R9: low power with chip select high
    chk(!en_a && !en_f && lp_a && lp_f, "R8 R9 release on chip select",
        int'({en_a, en_f}), 0);
    step(1'b1, 1'b0);
    chk(dac_a == 8'd0 && dac_f == 8'd0 && !bz_a && !bz_f, "R8 cleared after frame",
        int'(dac_a), 0);
    if (stop >= pre + 4)
      chk(r_ch[pre+4] == chn && r_df[pre+4] == !sgl, "R2 mux select",
          int'({r_df[pre+4], r_ch[pre+4]}), int'({!sgl, chn}));
    analyze(0, pre + 4, ea, stop);
    analyze(1, 2, ef, stop);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(posedge clk);
    #5;
    rst = 1'b0;
    step(1'b1, 1'b0);
    // R12 reset state
    chk(dac_a == 0 && !bz_a && !en_a && lp_a && !ch_a && !df_a && dac_f == 0,
        "R12 reset state", int'(dac_a), 0);

    // Directed: full scale, zero, alternating patterns
    va0 = 8'hFF; va1 = 8'h00; vf = 8'hFF;
    frame(0, 1'b1, 1'b0, 20);
    va0 = 8'h00; va1 = 8'h55; vf = 8'h00;
    frame(2, 1'b1, 1'b1, 22);
    va0 = 8'hAA; va1 = 8'h01; vf = 8'h55;
    frame(1, 1'b1, 1'b0, 21);

    // R10: differential, negative above positive, and equal inputs
    va0 = 8'h30; va1 = 8'h90; vf = 8'h7F;
    frame(0, 1'b0, 1'b0, 20);
    chk(r_dac[0][12] == 8'd0, "R10 negative above positive", int'(r_dac[0][12]), 0);
    va0 = 8'h44; va1 = 8'h44;
    frame(1, 1'b0, 1'b1, 21);
    chk(r_dac[0][13] == 8'd0, "R10 equal inputs", int'(r_dac[0][13]), 0);
    va0 = 8'h30; va1 = 8'h90;
    frame(0, 1'b0, 1'b1, 20);

    // R11: frames cut after the MSB-first pass (13 / 11 clock framing)
    va0 = 8'h9C; va1 = 8'h21; vf = 8'h3A;
    frame(0, 1'b1, 1'b0, 12);
    chk(r_dac[0][12] == 8'h9C, "R11 addressed result at edge 12", int'(r_dac[0][12]), 8'h9C);
    chk(r_dac[1][10] == 8'h3A, "R11 fixed result at edge 10", int'(r_dac[1][10]), 8'h3A);
    frame(0, 1'b1, 1'b1, 20);

    // R8: abort in the middle of the approximation
    va0 = 8'hE7; vf = 8'h18;
    frame(1, 1'b1, 1'b0, 8);
    frame(0, 1'b1, 1'b0, 20);

    // Random frames
    for (int n = 0; n < 24; n++) begin
      int pre;
      va0 = 8'($urandom);
      va1 = 8'($urandom);
      vf  = 8'($urandom);
      pre = int'($urandom % 4);
      frame(pre, 1'($urandom % 2), 1'($urandom % 2), pre + 20);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule